// File: doc/BRIEF.md
# Coprocessor Handshake Stall Controller

This block sits on the processor side of a coprocessor attachment. Each cycle it decides whether a coprocessor instruction runs, stalls the pipeline, raises an undefined-instruction trap, or is dropped. The coprocessor reports a two-bit handshake code on two buses. One bus answers for the instruction that is about to enter execute. The other answers for the instruction already in execute that needs more cycles. The controller reads whichever bus matches its current pipeline phase.

A waiting coprocessor holds the pipeline in a stall loop. An interrupt can break that loop. The controller then withdraws its pass signal, which tells the coprocessor to forget the instruction; the instruction is reissued later. The coprocessor may change its own state only while pass is high and its handshake shows a proceed code. A late-cancel output tells the coprocessor when the instruction ahead of it aborted on a data access.

Top module: `cop_hs_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the controller to idle. In the cycle after reset, `stall_o`, `undef_o`, `pass_o`, `cancel_o` and `done_o` are all low.
- R2: In idle, the controller acts on `hs_dec_i` only when `enter_i` is high at the clock edge, and it ignores `hs_ex_i`. Once the instruction is in execute, it uses `hs_ex_i` only. The handshake codes are: WAIT=2'b00, GO=2'b01, ABSENT=2'b10, LAST=2'b11.
- R3: ABSENT on the bus being read gives a one-cycle `undef_o` pulse in the next cycle. In that cycle `pass_o` and `stall_o` are low, and the controller returns to idle.
- R4: WAIT on the bus being read sets `stall_o` and `pass_o` high in the next cycle. Both stay high while `hs_ex_i` stays WAIT and `irq_i` stays low.
- R5: During a stall, `hs_ex_i` changing to ABSENT raises the trap (R3). Changing to GO ends the stall and execution continues. Changing to LAST completes the instruction (R8).
- R6: `irq_i` high at an edge during a stall drops `stall_o` and `pass_o` in the next cycle, with neither `done_o` nor `undef_o`. Outside a stall, `irq_i` has no effect.
- R7: GO keeps `pass_o` high in the next cycle with `stall_o` low. The controller then reads `hs_ex_i` at the following edge.
- R8: LAST gives a one-cycle `done_o` pulse with `pass_o` high in the next cycle. The controller is idle after that cycle.
- R9: The first execute cycle is the cycle after an accepted entry, meaning an entry whose code is not ABSENT. `cancel_o` is high in the cycle after the first execute cycle exactly when `prev_abort_i` was high during the first execute cycle. At all other times it is low.
- R10: In idle with `enter_i` low, no output goes high, whatever the handshake codes are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| enter_i | input | 1 | A coprocessor instruction enters execute next cycle |
| hs_dec_i | input | 2 | Handshake code for the entering instruction |
| hs_ex_i | input | 2 | Handshake code for the instruction in execute |
| irq_i | input | 1 | Interrupt request |
| prev_abort_i | input | 1 | Preceding instruction took a data abort |
| stall_o | output | 1 | Pipeline stall |
| undef_o | output | 1 | Undefined-instruction trap request |
| pass_o | output | 1 | Pass/commit permission to the coprocessor |
| cancel_o | output | 1 | Late cancel of the coprocessor instruction |
| done_o | output | 1 | Instruction complete pulse |

## Verification
The hardest case to reach is an interrupt breaking out of a stall. It needs an accepted entry, then a run of WAIT codes on the execute bus, then an interrupt that arrives while the stall is still held. Uniform random codes almost never stay on WAIT long enough for this. The random stimulus therefore weights the execute bus toward WAIT and asserts interrupts now and then. Directed sequences also build a stall that lasts several cycles before the interrupt fires. Late cancel gets a directed case of its own. In that case the abort flag is high only in the first execute cycle, and then only in a later cycle, to show that only the first one counts.

// File: rtl/cop_hs_ctrl.sv
module cop_hs_ctrl (
  input  logic       clk,
  input  logic       rst,
  input  logic       enter_i,
  input  logic [1:0] hs_dec_i,
  input  logic [1:0] hs_ex_i,
  input  logic       irq_i,
  input  logic       prev_abort_i,
  output logic       stall_o,
  output logic       undef_o,
  output logic       pass_o,
  output logic       cancel_o,
  output logic       done_o
);
  localparam logic [1:0] HS_WAIT = 2'b00;
  localparam logic [1:0] HS_GO   = 2'b01;
  localparam logic [1:0] HS_ABS  = 2'b10;
  localparam logic [1:0] HS_LAST = 2'b11;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_HOLD} st_t;

  st_t        st;
  logic       pass_q, undef_q, done_q, first_q, cancel_q;
  logic [1:0] code;
  logic       live, brk;

  assign code = (st == S_IDLE) ? hs_dec_i : hs_ex_i;
  assign live = (st != S_IDLE) || enter_i;
  assign brk  = (st == S_HOLD) && irq_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      pass_q   <= 1'b0;
      undef_q  <= 1'b0;
      done_q   <= 1'b0;
      first_q  <= 1'b0;
      cancel_q <= 1'b0;
    end else begin
      undef_q  <= 1'b0;
      done_q   <= 1'b0;
      first_q  <= (st == S_IDLE) && enter_i && (code != HS_ABS);
      cancel_q <= first_q && prev_abort_i;
      if (brk) begin
        st     <= S_IDLE;
        pass_q <= 1'b0;
      end else if (live) begin
        unique case (code)
          HS_ABS: begin
            st      <= S_IDLE;
            pass_q  <= 1'b0;
            undef_q <= 1'b1;
          end
          HS_WAIT: begin
            st     <= S_HOLD;
            pass_q <= 1'b1;
          end
          HS_GO: begin
            st     <= S_RUN;
            pass_q <= 1'b1;
          end
          HS_LAST: begin
            st     <= S_IDLE;
            pass_q <= 1'b1;
            done_q <= 1'b1;
          end
          default: st <= S_IDLE;
        endcase
      end else begin
        st     <= S_IDLE;
        pass_q <= 1'b0;
      end
    end
  end

  assign stall_o  = (st == S_HOLD);
  assign pass_o   = pass_q;
  assign undef_o  = undef_q;
  assign done_o   = done_q;
  assign cancel_o = cancel_q;
endmodule

module cop_hs_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] hs_ex_i,
  input logic       irq_i,
  input logic       prev_abort_i,
  input logic       stall_o,
  input logic       undef_o,
  input logic       pass_o,
  input logic       cancel_o,
  input logic       done_o
);
  AST_UNDEF_QUIET: assert property (@(posedge clk) disable iff (rst) undef_o |-> (!pass_o && !stall_o && !done_o)); // R3
  AST_STALL_PASS:  assert property (@(posedge clk) disable iff (rst) stall_o |-> pass_o); // R4
  AST_WAIT_HOLD:   assert property (@(posedge clk) disable iff (rst) (stall_o && !irq_i && hs_ex_i == 2'b00) |=> stall_o); // R4
  AST_IRQ_BREAK:   assert property (@(posedge clk) disable iff (rst) (stall_o && irq_i) |=> (!stall_o && !pass_o && !done_o && !undef_o)); // R6
  AST_GO_RUN:      assert property (@(posedge clk) disable iff (rst) (stall_o && !irq_i && hs_ex_i == 2'b01) |=> (pass_o && !stall_o)); // R7
  AST_DONE_PASS:   assert property (@(posedge clk) disable iff (rst) done_o |-> (pass_o && !stall_o)); // R8
  AST_CANCEL_SRC:  assert property (@(posedge clk) disable iff (rst) cancel_o |-> $past(prev_abort_i)); // R9
endmodule

bind cop_hs_ctrl cop_hs_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .hs_ex_i(hs_ex_i), .irq_i(irq_i), .prev_abort_i(prev_abort_i),
  .stall_o(stall_o), .undef_o(undef_o), .pass_o(pass_o), .cancel_o(cancel_o), .done_o(done_o)
);

// File: tb/cop_hs_ctrl_bench.sv
module cop_hs_ctrl_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enter_i = 1'b0, irq_i = 1'b0, prev_abort_i = 1'b0;
  logic [1:0] hs_dec_i = 2'b00, hs_ex_i = 2'b00;
  logic stall_o, undef_o, pass_o, cancel_o, done_o;
  int   n_run = 0, n_fail = 0;
  bit   finished = 0;

  always #5 clk = ~clk;

  cop_hs_ctrl u_cop_hs_ctrl (
    .clk(clk), .rst(rst), .enter_i(enter_i), .hs_dec_i(hs_dec_i), .hs_ex_i(hs_ex_i),
    .irq_i(irq_i), .prev_abort_i(prev_abort_i), .stall_o(stall_o), .undef_o(undef_o),
    .pass_o(pass_o), .cancel_o(cancel_o), .done_o(done_o)
  );

  // Expected-value model: phase 0 idle, 1 running after GO, 2 stalled
  int m_ph = 0;
  bit m_stall, m_undef, m_pass, m_cancel, m_done, m_first;

  function automatic int next_phase(int ph, bit ent, logic [1:0] dc, logic [1:0] ex, bit irq);
    logic [1:0] c;
    if (ph == 2 && irq) return 0;
    if (ph == 0 && !ent) return 0;
    c = (ph == 0) ? dc : ex;
    if (c == 2'b00) return 2;
    if (c == 2'b01) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    logic [1:0] c;
    bit act, brk;
    c   = (m_ph == 0) ? hs_dec_i : hs_ex_i;
    act = (m_ph != 0) || enter_i;
    brk = (m_ph == 2) && irq_i;
    if (rst) begin
      m_ph <= 0; m_undef <= 0; m_pass <= 0; m_done <= 0; m_cancel <= 0; m_first <= 0;
    end else begin
      m_ph     <= next_phase(m_ph, enter_i, hs_dec_i, hs_ex_i, irq_i);
      m_undef  <= !brk && act && c == 2'b10;
      m_done   <= !brk && act && c == 2'b11;
      m_pass   <= !brk && act && c != 2'b10;
      m_cancel <= m_first && prev_abort_i;
      m_first  <= m_ph == 0 && enter_i && hs_dec_i != 2'b10;
    end
  end
  assign m_stall = (m_ph == 2);

  task automatic chk(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit en, input logic [1:0] dc, input logic [1:0] ex, input bit irq, input bit ab);
    enter_i = en; hs_dec_i = dc; hs_ex_i = ex; irq_i = irq; prev_abort_i = ab;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk_model();
    chk("R4 stall", stall_o, m_stall);
    chk("R3 undef", undef_o, m_undef);
    chk("R7 pass", pass_o, m_pass);
    chk("R8 done", done_o, m_done);
    chk("R9 cancel", cancel_o, m_cancel);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    cyc(0, 2'b00, 2'b00, 0, 0);
    cyc(0, 2'b00, 2'b00, 0, 0);
    rst = 1'b0;
    // R1 reset state
    chk("R1 stall", stall_o, 0); chk("R1 pass", pass_o, 0); chk("R1 undef", undef_o, 0);
    chk("R1 done", done_o, 0); chk("R1 cancel", cancel_o, 0);
    // R10 idle without entry ignores codes
    cyc(0, 2'b10, 2'b00, 1, 1);
    chk("R10 undef", undef_o, 0); chk("R10 stall", stall_o, 0); chk("R10 pass", pass_o, 0);
    // R2 entry reads decode bus, not execute bus
    cyc(1, 2'b01, 2'b10, 0, 0);
    chk("R2 pass", pass_o, 1); chk("R2 undef", undef_o, 0);
    // R4 stall via execute bus, hold, then R6 interrupt breakout
    cyc(0, 2'b10, 2'b00, 0, 0);
    chk("R4 stall", stall_o, 1); chk("R4 pass", pass_o, 1);
    cyc(1, 2'b11, 2'b00, 0, 0);
    cyc(0, 2'b00, 2'b00, 0, 0);
    chk("R4 stall hold", stall_o, 1);
    cyc(0, 2'b00, 2'b00, 1, 0);
    chk("R6 stall", stall_o, 0); chk("R6 pass", pass_o, 0);
    chk("R6 done", done_o, 0); chk("R6 undef", undef_o, 0);
    // R6 irq outside a stall has no effect
    cyc(1, 2'b01, 2'b00, 1, 0);
    chk("R6 irq ignored pass", pass_o, 1);
    cyc(0, 2'b00, 2'b11, 1, 0);
    chk("R8 done", done_o, 1); chk("R8 pass", pass_o, 1);
    cyc(0, 2'b00, 2'b00, 0, 0);
    chk("R8 done pulse", done_o, 0); chk("R8 idle", pass_o, 0);
    // R5 stall resolving to GO, LAST, ABSENT
    cyc(1, 2'b00, 2'b00, 0, 0);
    cyc(0, 2'b00, 2'b01, 0, 0);
    chk("R5 go stall", stall_o, 0); chk("R7 go pass", pass_o, 1);
    cyc(0, 2'b00, 2'b00, 0, 0);
    cyc(0, 2'b00, 2'b11, 0, 0);
    chk("R5 last done", done_o, 1);
    cyc(1, 2'b00, 2'b00, 0, 0);
    cyc(0, 2'b00, 2'b10, 0, 0);
    chk("R5 absent undef", undef_o, 1); chk("R3 pass", pass_o, 0); chk("R5 stall", stall_o, 0);
    cyc(0, 2'b00, 2'b00, 0, 0);
    chk("R3 pulse", undef_o, 0);
    // R3 ABSENT on entry
    cyc(1, 2'b10, 2'b01, 0, 0);
    chk("R3 entry undef", undef_o, 1);
    // R9 late cancel
    cyc(1, 2'b01, 2'b00, 0, 0);
    cyc(0, 2'b00, 2'b01, 0, 1);
    chk("R9 cancel", cancel_o, 1);
    cyc(0, 2'b00, 2'b11, 0, 1);
    chk("R9 later abort", cancel_o, 0);
    cyc(0, 2'b00, 2'b00, 0, 0);
    // constrained random, weighted toward WAIT on the execute bus
    for (int i = 0; i < 3000; i++) begin
      bit en, irq, ab;
      logic [1:0] dc, ex;
      en  = ($urandom % 3) == 0;
      dc  = 2'($urandom);
      ex  = (($urandom % 2) == 0) ? 2'b00 : 2'($urandom);
      irq = ($urandom % 6) == 0;
      ab  = ($urandom % 3) == 0;
      cyc(en, dc, ex, irq, ab);
      chk_model();
    end
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule